// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block models the write side of a byte-wide nonvolatile memory that has an internal page latch. On a clocked interface it sees three active-high controls (chip enable, write enable, output enable), an address and a data byte. Each completed write strobe loads one byte into a 64-entry page buffer and sets that byte's valid flag. Every byte in one load sequence must belong to the page chosen by the first byte.

When no further byte arrives within a load window, the controller closes the buffer and starts an internal programming period. It raises `busy` for the whole period. At the end it copies only the flagged bytes into a behavioural storage array, clears the flags and returns to idle. Both windows are counted in clock cycles and are set by parameters. A read port returns the stored byte so that committed data can be seen.

Top module: `pgee_write_ctrl`

## Requirements
- R1: After reset `busy` and `page_err` are 0 and any partly loaded page is discarded. Reset leaves the storage array contents unchanged.
- R2: A write strobe is active only while `chip_en`=1, `wr_en`=1 and `out_en`=0. Any other combination loads nothing.
- R3: The address is taken on the first cycle of an active strobe. The data byte is taken on the first cycle after the strobe goes inactive.
- R4: Each accepted load restarts the load window. Programming starts (`busy` rises) exactly LOAD_WIN cycles after the clock edge that completed the last accepted load.
- R5: A load whose page bits (address bits above bit 5) differ from the page of the first byte in the sequence is dropped and sets `page_err`. `page_err` stays at 1 until reset.
- R6: Bytes may be loaded in any offset order. A second load to the same offset within one sequence replaces the first value.
- R7: At the end of programming, only the offsets loaded in the sequence are written. The other bytes of the page keep their values.
- R8: `busy` stays high for exactly PROG_CYC cycles.
- R9: Write strobes that begin while `busy` is high are ignored.
- R10: While `chip_en`=1, `out_en`=1 and `wr_en`=0, `rd_data` shows the stored byte at `addr`. Otherwise `rd_data` is 0.
- R11: A single sequence can load all 64 offsets of a page, and all 64 are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| wr_en | input | 1 | Write enable, active high |
| out_en | input | 1 | Output enable, active high; blocks writes |
| addr | input | ADDR_W | Byte address; bits 5..0 select the offset within a page |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, or 0 when no read is active |
| busy | output | 1 | Internal programming period in progress |
| page_err | output | 1 | Sticky flag: a load targeted a different page |

## Verification
The assertions assume that the controls change only between clock edges. They also assume that once programming starts, a load never completes until `busy` has fallen again, and that a sequence is never closed without at least one flagged byte. The stimulus drives every input on the falling clock edge. It keeps consecutive loads of a sequence closer together than LOAD_WIN cycles, except where the window is meant to expire. During programming it issues only strobes that test that such strobes are dropped. Reads happen only while the controller is idle, so the scoreboard compares against storage that is not changing.

// File: rtl/pgee_pkg.sv
package pgee_pkg;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 6;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef logic [DATA_W-1:0]                   byte_t;
    typedef logic [PAGE_BYTES-1:0]               flag_vec_t;
    typedef logic [PAGE_BYTES-1:0][DATA_W-1:0]   page_data_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_PROG
    } seq_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        byte_t            data;
    } byte_load_t;

    // a write strobe needs chip and write enable with the output driver off
    function automatic logic strobe_active(input logic ce, input logic we, input logic oe);
        return ce & we & ~oe;
    endfunction
endpackage

// File: rtl/pgee_strobe.sv
module pgee_strobe
    import pgee_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    input  logic              accept,
    output logic              strobe_act,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output byte_t             load_data
);
    logic              act_q;
    logic              armed_q;
    logic [ADDR_W-1:0] addr_q;

    assign strobe_act = strobe_active(chip_en, wr_en, out_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            act_q <= strobe_act;
            if (strobe_act && !act_q) begin
                addr_q  <= addr;     // address taken at strobe start
                armed_q <= accept;   // strobes begun while programming are dropped
            end
        end
    end

    // strobe end: data is taken from the bus in this cycle
    assign load_valid = act_q & ~strobe_act & armed_q;
    assign load_addr  = addr_q;
    assign load_data  = wdata;
endmodule

// File: rtl/pgee_page_buf.sv
module pgee_page_buf
    import pgee_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    input  byte_t             load_data,
    input  logic              clear,
    input  logic              busy,
    output logic              load_ok,
    output flag_vec_t         flags,
    output page_data_t        bytes,
    output logic [ADDR_W-OFS_W-1:0] page_num,
    output logic              page_err
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    byte_load_t        ld;
    logic [PAGE_W-1:0] ld_page;
    logic              have_page;
    logic              page_match;

    assign ld.ofs     = load_addr[OFS_W-1:0];
    assign ld.data    = load_data;
    assign ld_page    = load_addr[ADDR_W-1:OFS_W];
    assign have_page  = |flags;
    assign page_match = !have_page || (ld_page == page_num);
    assign load_ok    = load_valid && page_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            bytes    <= '0;
            page_num <= '0;
            page_err <= 1'b0;
        end else begin
            if (clear) begin
                flags <= '0;
            end else if (load_ok) begin
                flags[ld.ofs] <= 1'b1;
                bytes[ld.ofs] <= ld.data;
                if (!have_page) begin
                    page_num <= ld_page;
                end
            end
            if (load_valid && !page_match) begin
                page_err <= 1'b1;
            end
        end
    end

    a_r9_no_load_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load_valid);
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        page_err |=> page_err);
    a_r4_prog_has_bytes: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (flags != '0));
    a_r7_flags_clear_after_prog: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (flags == '0));
endmodule

// File: rtl/pgee_seq.sv
module pgee_seq
    import pgee_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_ok,
    input  logic strobe_act,
    output logic busy,
    output logic commit
);
    localparam int WIN_W  = $clog2(LOAD_WIN + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    seq_state_e        state;
    logic [WIN_W-1:0]  win_cnt;
    logic [PROG_W-1:0] prog_cnt;
    logic              win_done;
    logic              prog_done;

    assign win_done  = (win_cnt == WIN_W'(LOAD_WIN - 1));
    assign prog_done = (prog_cnt == PROG_W'(PROG_CYC - 1));
    assign busy      = (state == SEQ_PROG);
    assign commit    = busy && prog_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            win_cnt  <= '0;
            prog_cnt <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (load_ok) begin
                        state   <= SEQ_LOAD;
                        win_cnt <= '0;
                    end
                end
                SEQ_LOAD: begin
                    if (load_ok) begin
                        win_cnt <= '0;
                    end else if (!strobe_act) begin
                        if (win_done) begin
                            state    <= SEQ_PROG;
                            prog_cnt <= '0;
                        end else begin
                            win_cnt <= win_cnt + 1'b1;
                        end
                    end
                end
                SEQ_PROG: begin
                    if (prog_done) begin
                        state <= SEQ_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgee_array.sv
module pgee_array
    import pgee_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic [ADDR_W-OFS_W-1:0] page_num,
    input  flag_vec_t               flags,
    input  page_data_t              bytes,
    input  logic [ADDR_W-1:0]       rd_addr,
    output byte_t                   rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (flags[i]) begin
                    mem[{page_num, OFS_W'(i)}] <= bytes[i];
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];

    a_r7_commit_has_flags: assert property (@(posedge clk)
        commit |-> (flags != '0));
endmodule

// File: rtl/pgee_write_ctrl.sv
module pgee_write_ctrl
    import pgee_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              page_err
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              strobe_act;
    logic              load_valid;
    logic [ADDR_W-1:0] load_addr;
    byte_t             load_data;
    logic              load_ok;
    logic              commit;
    flag_vec_t         flags;
    page_data_t        bytes;
    logic [PAGE_W-1:0] page_num;
    byte_t             rd_byte;
    logic              rd_active;

    pgee_strobe #(.ADDR_W(ADDR_W)) i_strobe (
        .clk(clk), .rst(rst),
        .chip_en(chip_en), .wr_en(wr_en), .out_en(out_en),
        .addr(addr), .wdata(wdata), .accept(!busy),
        .strobe_act(strobe_act), .load_valid(load_valid),
        .load_addr(load_addr), .load_data(load_data)
    );

    pgee_page_buf #(.ADDR_W(ADDR_W)) i_page_buf (
        .clk(clk), .rst(rst),
        .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data),
        .clear(commit), .busy(busy),
        .load_ok(load_ok), .flags(flags), .bytes(bytes),
        .page_num(page_num), .page_err(page_err)
    );

    pgee_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) i_seq (
        .clk(clk), .rst(rst),
        .load_ok(load_ok), .strobe_act(strobe_act),
        .busy(busy), .commit(commit)
    );

    pgee_array #(.ADDR_W(ADDR_W)) i_array (
        .clk(clk), .commit(commit),
        .page_num(page_num), .flags(flags), .bytes(bytes),
        .rd_addr(addr), .rd_byte(rd_byte)
    );

    assign rd_active = chip_en & out_en & ~wr_en;
    assign rd_data   = rd_active ? rd_byte : '0;
endmodule

// File: tb/test_pgee_write_ctrl.sv
module test_pgee_write_ctrl;
    localparam int AW = 10;
    localparam int LW = 20;
    localparam int PC = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b0, we = 1'b0, oe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rd_data;
    logic          busy, page_err;

    always #10 clk = ~clk;

    pgee_write_ctrl #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) i_pgee_write_ctrl (
        .clk(clk), .rst(rst), .chip_en(ce), .wr_en(we), .out_en(oe),
        .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .busy(busy), .page_err(page_err)
    );

    typedef struct { int a; logic [7:0] d; string tag; } rd_item_t;
    rd_item_t   exp_q[$];
    logic [7:0] model [1 << AW];
    bit         pend_v [64];
    logic [7:0] pend_d [64];
    int         pend_page;
    int         n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares every read cycle against the queued expectation
    initial forever begin
        @(posedge clk);
        #5;
        if (ce && oe && !we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read", rd_data, 0);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk(rd_data === it.d, it.tag, rd_data, it.d);
            end
        end
    end

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        ce = 1; oe = 1; we = 0; addr = AW'(a);
        exp_q.push_back('{a, model[a], tag});
        @(negedge clk);
        ce = 0; oe = 0;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input bit cev = 1, input bit oev = 0);
        @(negedge clk);
        ce = cev; oe = oev; we = 1; addr = AW'(a); wdata = d;
        @(negedge clk);
        we = 0;
        if (oev) ce = 0;
        @(negedge clk);
        ce = 0; oe = 0;
    endtask

    task automatic stage(input int a, input logic [7:0] d);
        pend_v[a % 64] = 1'b1;
        pend_d[a % 64] = d;
        pend_page = a / 64;
    endtask

    task automatic settle();
        repeat (LW + PC + 3) @(negedge clk);
        chk(busy == 1'b0, "R8 busy low after programming", busy, 0);
        for (int i = 0; i < 64; i++) begin
            if (pend_v[i]) model[pend_page * 64 + i] = pend_d[i];
            pend_v[i] = 1'b0;
        end
    endtask

    task automatic rd_page(input int p, input string tag);
        for (int i = 0; i < 64; i++) rd(p * 64 + i, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(page_err == 1'b0, "R1 page_err after reset", page_err, 0);
        chk(rd_data == 8'h00, "R10 idle rd_data", rd_data, 0);

        // R11: full page 1, with exact window and programming timing (R4, R8)
        for (int i = 0; i < 64; i++) begin
            wr(64 + i, 8'(i * 7 + 3));
            stage(64 + i, 8'(i * 7 + 3));
        end
        repeat (LW - 1) @(negedge clk);
        chk(busy == 1'b0, "R4 busy before window end", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R4 busy at window end", busy, 1);
        repeat (PC - 1) @(negedge clk);
        chk(busy == 1'b1, "R8 busy last cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy drop", busy, 0);
        settle();
        rd_page(1, "R11 full page readback");

        // R6 any order, R4 window restarts per load: page 2 from the top down
        for (int i = 63; i >= 0; i--) begin
            wr(128 + i, 8'(8'hC0 ^ i));
            stage(128 + i, 8'(8'hC0 ^ i));
            repeat (LW - 5) @(negedge clk);
            if (i % 16 == 0) chk(busy == 1'b0, "R4 window restarted", busy, 0);
        end
        settle();
        rd_page(2, "R6 reverse order page");

        // R7 partial update with R6 overwrite
        wr(64 + 10, 8'hAA);
        wr(64 + 3, 8'hBB);
        wr(64 + 10, 8'hCC);
        stage(64 + 3, 8'hBB);
        stage(64 + 10, 8'hCC);
        settle();
        rd_page(1, "R7 only loaded bytes change");

        // R3: address from strobe start, data from strobe end
        @(negedge clk);
        ce = 1; we = 1; addr = AW'(128 + 5); wdata = 8'h11;
        @(negedge clk);
        addr = AW'(128 + 6); wdata = 8'h22;
        @(negedge clk);
        we = 0; wdata = 8'h33;
        @(negedge clk);
        ce = 0;
        stage(128 + 5, 8'h33);
        settle();
        rd(128 + 5, "R3 data at strobe end");
        rd(128 + 6, "R3 later address ignored");

        // R2: output enable or missing chip enable blocks a write
        wr(64 + 0, 8'h5E, 1'b1, 1'b1);
        wr(64 + 1, 8'h5F, 1'b0, 1'b0);
        seen = 0;
        repeat (LW + PC) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, "R2 no programming started", seen, 0);
        rd(64 + 0, "R2 out_en blocks write");
        rd(64 + 1, "R2 chip_en low blocks write");

        // R9: strobe during programming is dropped
        wr(64 + 20, 8'h44);
        stage(64 + 20, 8'h44);
        repeat (LW + 2) @(negedge clk);
        chk(busy == 1'b1, "R9 programming active", busy, 1);
        wr(64 + 21, 8'h55);
        settle();
        rd(64 + 20, "R9 sequence byte committed");
        rd(64 + 21, "R9 byte during busy ignored");

        // R5: foreign page dropped, flag sticky
        wr(64 + 30, 8'h66);
        stage(64 + 30, 8'h66);
        chk(page_err == 1'b0, "R5 no error yet", page_err, 0);
        wr(128 + 30, 8'h77);
        chk(page_err == 1'b1, "R5 error raised", page_err, 1);
        settle();
        chk(page_err == 1'b1, "R5 error sticky", page_err, 1);
        rd(64 + 30, "R5 first page committed");
        rd(128 + 30, "R5 foreign page untouched");

        // R1: reset mid-load drops the sequence, keeps the array
        wr(64 + 40, 8'h99);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after mid-load reset", busy, 0);
        chk(page_err == 1'b0, "R1 page_err cleared", page_err, 0);
        seen = 0;
        repeat (LW + PC) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, "R1 dropped sequence not programmed", seen, 0);
        rd(64 + 40, "R1 discarded load");
        rd(64 + 10, "R1 array kept");
        rd(128 + 63, "R1 array kept");

        // R10: no read without chip_en and out_en with wr_en low
        @(negedge clk);
        ce = 1; oe = 0; we = 0; addr = AW'(64 + 10);
        #5 chk(rd_data == 8'h00, "R10 out_en low", rd_data, 0);
        @(negedge clk);
        ce = 0; oe = 1;
        #5 chk(rd_data == 8'h00, "R10 chip_en low", rd_data, 0);
        @(negedge clk);
        oe = 0;
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads observed", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule